// File: doc/BRIEF.md
# Synchronous SCSI transfer-rate strobe generator

This block derives the timing strobes for a synchronous SCSI data path from a single fast reference clock. A prescaler divides the reference by a ratio taken from a 3-bit prescale code. Its output enable drives two counters. The send counter divides by the 3-bit period field plus four. The receive counter always divides by four. A second prescaler, with its own 3-bit code and the same ratio table, gives the enable for the asynchronous side of the controller.

Every output is a clock enable in the reference domain. No derived clock or gated clock exists. The 1.5 ratio is made by alternating gaps of one and two reference cycles between prescale enables. A new code or period value is adopted only at the edge that closes a complete period of the divider it affects, so no output ever shows a truncated or stretched period. System software must keep the prescaler output at or below 160 MHz. The block itself does not enforce this limit.

Top module: `sync_rate_gen`

## Requirements
- R1: With `pre_code` held at 001, 011, 000, 100, 101, 110 or 111, the prescale ratio is 1, 2, 3, 3, 4, 6 or 8 respectively. `pre_en` is high in exactly every Nth cycle, counted from the first cycle after reset release. For ratio 1 it stays high.
- R2: With `pre_code` = 010, the ratio is 1.5. `pre_en` is high in cycles 2, 3, 5, 6, 8, 9 and so on after release, so the gaps alternate between two cycles and one cycle.
- R3: `send_en` is high exactly in the cycle of every (`period_code` + 4)th `pre_en` pulse, so the send divisor ranges from 4 to 11.
- R4: `recv_en` is high exactly in the cycle of every 4th `pre_en` pulse, whatever `period_code` holds.
- R5: `send_en` and `recv_en` are never high in a cycle where `pre_en` is low.
- R6: `core_en` follows the R1 and R2 ratio table using `core_code`, independently of `pre_code`. A new `core_code` is adopted only at the end of a complete core period.
- R7: The reset is synchronous and active high. After a clock edge with `rst` high, all four outputs are low. After release, every divider restarts from zero, so each first pulse arrives one full divided period later.
- R8: A change of `pre_code` takes effect only at the edge that closes a complete prescale period. For the 1.5 ratio, this is the edge after every second pulse. Until then the old ratio continues.
- R9: A change of `period_code` takes effect only at the edge that ends a `send_en` cycle. The send period in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (quadrupled clock) |
| rst | input | 1 | Synchronous reset, active high |
| pre_code | input | 3 | Prescale ratio code |
| period_code | input | 3 | Send period field; send divisor is value plus 4 |
| core_code | input | 3 | Ratio code for the asynchronous-logic enable |
| pre_en | output | 1 | Prescaler output enable |
| send_en | output | 1 | Send strobe enable |
| recv_en | output | 1 | Receive strobe enable |
| core_en | output | 1 | Asynchronous-logic enable |

## Verification
`pre_en` and `core_en` come from registers. A pulse that completes the Nth reference cycle after release, or after the last boundary, therefore shows in the cycle that follows the Nth edge. `send_en` and `recv_en` are combinational on top of `pre_en`, so they appear in the same cycle as the prescale pulse that completes their count. A new prescale or core code is taken at the edge that registers a boundary pulse. A new period value is taken at the edge that ends the `send_en` cycle. The bench samples at each falling edge and keeps its own pulse counters to reproduce these cycles. It changes inputs only right after a sample, so every code change lands at a known edge.

// File: rtl/rate_pkg.sv
package rate_pkg;
  // Width of every ratio or period code.
  localparam int CODE_W   = 3;
  // Prescale targets are held in half-cycle units, so 1.5 fits as 3.
  localparam int HALF_MAX = 16;
  localparam int HALF_W   = $clog2(HALF_MAX + 2);
  // Send divisor offset and the fixed receive divisor.
  localparam int SEND_BIAS = 4;
  localparam int RECV_DIV  = 4;
  localparam int SEND_MAX  = (1 << CODE_W) - 1 + SEND_BIAS;
  localparam int DIV_MAX   = (SEND_MAX > RECV_DIV) ? SEND_MAX : RECV_DIV;
  localparam int DIV_W     = $clog2(DIV_MAX + 1);

  // Ratio code to divisor in half-cycle units (the table is not monotonic).
  function automatic logic [HALF_W-1:0] half_div(input logic [CODE_W-1:0] c);
    logic [HALF_W-1:0] h;
    case (c)
      3'b001:  h = HALF_W'(2);
      3'b010:  h = HALF_W'(3);
      3'b011:  h = HALF_W'(4);
      3'b101:  h = HALF_W'(8);
      3'b110:  h = HALF_W'(12);
      3'b111:  h = HALF_W'(16);
      default: h = HALF_W'(6);   // 000 and 100 both mean three
    endcase
    return h;
  endfunction

  // Send divisor from the period field.
  function automatic logic [DIV_W-1:0] send_div(input logic [CODE_W-1:0] p);
    return DIV_W'(p) + DIV_W'(SEND_BIAS);
  endfunction
endpackage

// File: rtl/frac_prescaler.sv
module frac_prescaler
  import rate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic              tick,
  output logic              bound,
  output logic [HALF_W-1:0] tgt
);
  logic [HALF_W-1:0] acc;
  logic [HALF_W-1:0] acc_sum;
  logic              hit;

  // Two half-cycle units accrue per reference cycle.
  always_comb begin
    acc_sum = acc + HALF_W'(2);
    hit     = (acc_sum >= tgt);
    bound   = (acc_sum == tgt);   // period closes with no half-cycle left over
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      tick <= 1'b0;
      tgt  <= half_div(code);
    end else begin
      tick <= hit;
      if (hit) begin
        acc <= acc_sum - tgt;
        if (bound) tgt <= half_div(code);
      end else begin
        acc <= acc_sum;
      end
    end
  end
endmodule

// File: rtl/strobe_divider.sv
module strobe_divider #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] div_in,
  output logic         strobe,
  output logic [W-1:0] div_q
);
  logic [W-1:0] cnt;
  logic         last;

  assign last   = (cnt == div_q - W'(1));
  assign strobe = step & last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      div_q <= div_in;
    end else if (step) begin
      if (last) begin
        cnt   <= '0;
        div_q <= div_in;   // new divisor only at a period boundary
      end else begin
        cnt <= cnt + W'(1);
      end
    end
  end
endmodule

// File: rtl/sync_rate_gen.sv
module sync_rate_gen
  import rate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] pre_code,
  input  logic [CODE_W-1:0] period_code,
  input  logic [CODE_W-1:0] core_code,
  output logic              pre_en,
  output logic              send_en,
  output logic              recv_en,
  output logic              core_en
);
  // Named internal events, brought out for the bound checker.
  logic              pre_bound;
  logic [HALF_W-1:0] pre_tgt;
  logic              core_bound;
  logic [HALF_W-1:0] core_tgt;
  logic [DIV_W-1:0]  send_div_q;
  logic [DIV_W-1:0]  recv_div_q;

  frac_prescaler u_pre (
    .clk   (clk),
    .rst   (rst),
    .code  (pre_code),
    .tick  (pre_en),
    .bound (pre_bound),
    .tgt   (pre_tgt)
  );

  frac_prescaler u_core (
    .clk   (clk),
    .rst   (rst),
    .code  (core_code),
    .tick  (core_en),
    .bound (core_bound),
    .tgt   (core_tgt)
  );

  strobe_divider #(.W(DIV_W)) u_send (
    .clk    (clk),
    .rst    (rst),
    .step   (pre_en),
    .div_in (send_div(period_code)),
    .strobe (send_en),
    .div_q  (send_div_q)
  );

  strobe_divider #(.W(DIV_W)) u_recv (
    .clk    (clk),
    .rst    (rst),
    .step   (pre_en),
    .div_in (DIV_W'(RECV_DIV)),
    .strobe (recv_en),
    .div_q  (recv_div_q)
  );
endmodule

// File: rtl/rate_gen_chk.sv
module rate_gen_chk
  import rate_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              pre_en,
  input logic              send_en,
  input logic              recv_en,
  input logic              core_en,
  input logic              pre_bound,
  input logic [HALF_W-1:0] pre_tgt,
  input logic              core_bound,
  input logic [HALF_W-1:0] core_tgt,
  input logic [DIV_W-1:0]  send_div_q,
  input logic [DIV_W-1:0]  recv_div_q
);
  // R5
  send_sub_chk: assert property (@(posedge clk) disable iff (rst)
    send_en |-> pre_en);
  // R5
  recv_sub_chk: assert property (@(posedge clk) disable iff (rst)
    recv_en |-> pre_en);
  // R7
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> !(pre_en || send_en || recv_en || core_en));
  // R4
  recv_gap_chk: assert property (@(posedge clk) disable iff (rst)
    recv_en |=> !recv_en);
  // R4
  recv_div_chk: assert property (@(posedge clk) disable iff (rst)
    !recv_en |=> $stable(recv_div_q));
  // R8
  pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pre_bound |=> $stable(pre_tgt));
  // R6
  core_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !core_bound |=> $stable(core_tgt));
  // R9
  send_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !send_en |=> $stable(send_div_q));
endmodule

bind sync_rate_gen rate_gen_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .pre_en     (pre_en),
  .send_en    (send_en),
  .recv_en    (recv_en),
  .core_en    (core_en),
  .pre_bound  (pre_bound),
  .pre_tgt    (pre_tgt),
  .core_bound (core_bound),
  .core_tgt   (core_tgt),
  .send_div_q (send_div_q),
  .recv_div_q (recv_div_q)
);

// File: tb/sync_rate_gen_tb.sv
`timescale 1ns/1ps
module sync_rate_gen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] pre_code = 3'b001;
  logic [2:0] period_code = 3'b000;
  logic [2:0] core_code = 3'b001;
  logic pre_en, send_en, recv_en, core_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  sync_rate_gen u_dut (
    .clk(clk), .rst(rst), .pre_code(pre_code), .period_code(period_code),
    .core_code(core_code), .pre_en(pre_en), .send_en(send_en),
    .recv_en(recv_en), .core_en(core_en)
  );

  // Ratio table in half cycles, indexed by code.
  int half_tbl [8] = '{6, 2, 3, 4, 6, 8, 12, 16};

  // Model state.
  int mk_pre, mt_pre, mk_core, mt_core, m_pcnt, m_rcnt, m_sdiv;
  bit send_pend;

  // Per-scenario mismatch tallies: 0 pre, 1 send, 2 recv, 3 core, 4 sub.
  int bad [5];
  bit f_act [5];
  bit f_exp [5];
  int f_cyc [5];
  int cyc;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit pulse_at(input int k, input int t);
    return ((2 * k) / t) > ((2 * (k - 1)) / t);
  endfunction

  task automatic note(input int i, input bit a, input bit e);
    if (a !== e) begin
      if (bad[i] == 0) begin f_act[i] = a; f_exp[i] = e; f_cyc[i] = cyc; end
      bad[i]++;
    end
  endtask

  // R7: reset with given inputs, check quiet outputs, release, restart model.
  task automatic do_reset(input logic [2:0] pc, input logic [2:0] per,
                          input logic [2:0] cc);
    pre_code = pc; period_code = per; core_code = cc; rst = 1'b1;
    repeat (3) @(negedge clk);
    check({pre_en, send_en, recv_en, core_en} == 4'b0000, "R7",
          "outputs during reset", int'({pre_en, send_en, recv_en, core_en}), 0);
    rst = 1'b0;
    mk_pre = 0; mt_pre = half_tbl[pc]; mk_core = 0; mt_core = half_tbl[cc];
    m_pcnt = 0; m_rcnt = 0; m_sdiv = int'(per) + 4; send_pend = 1'b0; cyc = 0;
    for (int i = 0; i < 5; i++) bad[i] = 0;
  endtask

  // One falling-edge sample, compared with the model.
  task automatic step();
    bit e_pre, e_core, e_send, e_recv;
    @(negedge clk);
    cyc++;
    if (send_pend) begin m_sdiv = int'(period_code) + 4; send_pend = 1'b0; end
    mk_pre++;
    e_pre = pulse_at(mk_pre, mt_pre);
    if (e_pre && ((2 * mk_pre) % mt_pre == 0)) begin
      mk_pre = 0; mt_pre = half_tbl[pre_code];
    end
    mk_core++;
    e_core = pulse_at(mk_core, mt_core);
    if (e_core && ((2 * mk_core) % mt_core == 0)) begin
      mk_core = 0; mt_core = half_tbl[core_code];
    end
    e_send = 1'b0; e_recv = 1'b0;
    if (e_pre) begin
      m_pcnt++; m_rcnt++;
      if (m_pcnt == m_sdiv) begin e_send = 1'b1; m_pcnt = 0; send_pend = 1'b1; end
      if (m_rcnt == 4) begin e_recv = 1'b1; m_rcnt = 0; end
    end
    note(0, pre_en, e_pre);
    note(1, send_en, e_send);
    note(2, recv_en, e_recv);
    note(3, core_en, e_core);
    note(4, (send_en | recv_en) & ~pre_en, 1'b0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic report(input string tag_pre, input string tag_core);
    check(bad[0] == 0, tag_pre, $sformatf("pre_en cycle %0d", f_cyc[0]), f_act[0], f_exp[0]);
    check(bad[1] == 0, "R3 R9", $sformatf("send_en cycle %0d", f_cyc[1]), f_act[1], f_exp[1]);
    check(bad[2] == 0, "R4", $sformatf("recv_en cycle %0d", f_cyc[2]), f_act[2], f_exp[2]);
    check(bad[3] == 0, tag_core, $sformatf("core_en cycle %0d", f_cyc[3]), f_act[3], f_exp[3]);
    check(bad[4] == 0, "R5", $sformatf("strobe without pre_en cycle %0d", f_cyc[4]), f_act[4], f_exp[4]);
  endtask

  // R1 R3 R4: every integer ratio code with varied period fields.
  task automatic t_integer_codes();
    logic [2:0] codes [7] = '{3'b001, 3'b011, 3'b000, 3'b100, 3'b101, 3'b110, 3'b111};
    for (int i = 0; i < 7; i++) begin
      do_reset(codes[i], 3'(i), 3'b001);
      run(140);
      report("R1", "R6");
    end
  endtask

  // R2: ratio 1.5, with explicit first-pulse cycles.
  task automatic t_frac();
    bit seen [6];
    do_reset(3'b010, 3'b000, 3'b010);
    for (int i = 0; i < 6; i++) begin step(); seen[i] = pre_en; end
    check({seen[0], seen[1], seen[2], seen[3], seen[4], seen[5]} == 6'b011011,
          "R2", "first six pre_en samples",
          int'({seen[0], seen[1], seen[2], seen[3], seen[4], seen[5]}), 'b011011);
    run(60);
    report("R2", "R6 R2");
  endtask

  // R6: core ratio independent of the prescale ratio, and its boundary load.
  task automatic t_core();
    do_reset(3'b111, 3'b011, 3'b001);
    run(20);
    core_code = 3'b110;
    run(2);
    core_code = 3'b101;
    run(50);
    report("R1", "R6");
  endtask

  // R8: prescale change mid-period, integer and 1.5 ratios.
  task automatic t_pre_change();
    do_reset(3'b101, 3'b000, 3'b001);
    run(5);
    pre_code = 3'b001;
    run(40);
    report("R8", "R6");
    do_reset(3'b010, 3'b001, 3'b001);
    run(2);
    pre_code = 3'b111;
    run(80);
    report("R8", "R6");
  endtask

  // R9: period change part-way through a send period.
  task automatic t_period_change();
    do_reset(3'b001, 3'b000, 3'b011);
    run(6);
    period_code = 3'b111;
    run(30);
    period_code = 3'b010;
    run(40);
    report("R1", "R6");
  endtask

  // R7: reset in the middle of activity restarts every divider.
  task automatic t_midrun_reset();
    do_reset(3'b011, 3'b001, 3'b100);
    run(17);
    do_reset(3'b011, 3'b001, 3'b100);
    run(30);
    report("R7 R1", "R7 R6");
  endtask

  initial begin
    t_integer_codes();
    t_frac();
    t_core();
    t_pre_change();
    t_period_change();
    t_midrun_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule